// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Monitor

This block observes the command stream that a memory controller sends to a four-bank DDR SDRAM device. It raises an error whenever a command arrives before the minimum spacing that the device needs from an earlier command. It also reports a row that has stayed open past its allowed lifetime, and a refresh that has fallen overdue. The block is passive. It watches a command-valid strobe, a decoded command code and a bank address, and it never stalls or alters the stream.

Every timing limit is a parameter. Limits given in picoseconds are turned into clock cycles at elaboration by rounding up against the clock period parameter. Each bank has its own set of down-counters. Shared counters cover the rules that span banks or the whole device. A command that breaks a rule is still applied to the tracked state, so the checks that follow stay consistent with what the device actually received.

Top module: `ddr_tchk`

## Requirements
- R1: Reset closes every bank and clears every timing counter, so the first command after reset raises no violation. While reset is held, all outputs stay low.
- R2: Command codes on `cmd_i` are NOP=0, ACTIVE=1, READ=2, WRITE=3, READ+autoprecharge=4, WRITE+autoprecharge=5, PRECHARGE=6, REFRESH=7, MODE SET=8 and SELF-REFRESH EXIT=9. A command that breaks a rule drives `viol_o` high for exactly the cycle after the command is sampled, with the rule code on `viol_rule_o`. When several rules fail together, the lowest code is reported. The command still updates the tracked state.
- R3: Any command fewer than tMRD cycles after MODE SET reports code 1.
- R4: After SELF-REFRESH EXIT, a non-read command issued within tXSNR reports code 2. A READ issued within tXSRD cycles reports code 3.
- R5: An ACTIVE or REFRESH issued within tRFC after a REFRESH reports code 4.
- R6: A READ or WRITE, with or without autoprecharge, issued to a bank with no open row reports code 5.
- R7: A column command issued within tRCD of its bank's ACTIVE reports code 6. A READ+autoprecharge issued within max(tRCD, tRAS) of that ACTIVE reports code 7. A command issued exactly at the limit is accepted.
- R8: A column command issued within tCCD of the previous column command reports code 8. A READ issued within (write-data time + tWTR) of a WRITE reports code 9.
- R9: A PRECHARGE to an open bank issued within tRAS of its ACTIVE reports code 10. A PRECHARGE issued within (write-data time + tWR) of a WRITE to that bank reports code 11.
- R10: An ACTIVE issued within tRC of the previous ACTIVE to the same bank, or a REFRESH issued within tRC of an ACTIVE to any bank, reports code 12. An ACTIVE issued within tRP of a PRECHARGE to that bank reports code 13.
- R11: An ACTIVE issued to a bank within (write-data time + ceil(tWR/tCK) + ceil(tRP/tCK)) of a WRITE+autoprecharge to that bank reports code 14.
- R12: An ACTIVE issued within tRRD of an ACTIVE to a different bank reports code 15.
- R13: `refresh_due_o` rises once tREFI cycles have passed since reset or since the last REFRESH. A REFRESH clears it.
- R14: `row_overdue_o` is high while some bank has held its row open for at least the tRAS maximum in cycles. Closing that row clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_vld_i | input | 1 | Command on `cmd_i` is valid this cycle |
| cmd_i | input | 4 | Decoded command code (see R2) |
| bank_i | input | BA_W | Target bank address |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_rule_o | output | 4 | Code of the violated rule, 0 when none |
| refresh_due_o | output | 1 | Refresh interval has elapsed |
| row_overdue_o | output | 1 | A row has exceeded its open-time limit |

## Verification
A single scripted stream walks through bank opens, column accesses, precharges, mode setting, refresh and self-refresh exit. It places each command either one cycle early or exactly at its limit, so a rule that is off by one shows up as a wrong code or as a missing or extra pulse. Some steps break two rules at once to confirm that the lower code wins. Other steps target a closed bank or a different bank, to separate the per-bank rules from the cross-bank rules. Long idle stretches then approach the refresh interval and the row-lifetime limit, probing each threshold on the cycle before it and on the cycle it is reached.

// File: rtl/ddr_tchk_pkg.sv
package ddr_tchk_pkg;

   typedef enum logic [3:0] {
      CMD_NOP = 4'd0,
      CMD_ACT = 4'd1,
      CMD_RD  = 4'd2,
      CMD_WR  = 4'd3,
      CMD_RDA = 4'd4,
      CMD_WRA = 4'd5,
      CMD_PRE = 4'd6,
      CMD_REF = 4'd7,
      CMD_MRS = 4'd8,
      CMD_SRX = 4'd9
   } cmd_e;

   // Lower code wins when several rules fail together.
   typedef enum logic [3:0] {
      RULE_NONE  = 4'd0,
      RULE_MRD   = 4'd1,
      RULE_XSNR  = 4'd2,
      RULE_XSRD  = 4'd3,
      RULE_RFC   = 4'd4,
      RULE_NOROW = 4'd5,
      RULE_RCD   = 4'd6,
      RULE_RAP   = 4'd7,
      RULE_CCD   = 4'd8,
      RULE_WTR   = 4'd9,
      RULE_RAS   = 4'd10,
      RULE_WREC  = 4'd11,
      RULE_RC    = 4'd12,
      RULE_RP    = 4'd13,
      RULE_DAL   = 4'd14,
      RULE_RRD   = 4'd15
   } rule_e;

   localparam int unsigned NRULE = 15;

   // Picoseconds to whole clock cycles, rounded up.
   function automatic int unsigned ps2ck(input int unsigned ps, input int unsigned tck);
      return (ps + tck - 1) / tck;
   endfunction

   // Counter preload for a limit of n cycles (counter reads n-1 one cycle later).
   function automatic int unsigned ldval(input int unsigned n);
      return (n == 0) ? 0 : n - 1;
   endfunction

   function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_tchk_dcnt.sv
module ddr_tchk_dcnt #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          busy_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (load_i)       cnt_q <= val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ddr_tchk_bank.sv
module ddr_tchk_bank
   import ddr_tchk_pkg::*;
#(
   parameter int CW           = 8,
   parameter int AGE_W        = 14,
   parameter bit ROW_LIMIT_EN = 1'b1,
   parameter int RAS_CK       = 8,
   parameter int RC_CK        = 11,
   parameter int RP_CK        = 3,
   parameter int RCD_CK       = 3,
   parameter int RAP_CK       = 8,
   parameter int WREC_CK      = 6,
   parameter int DAL_CK       = 9,
   parameter int RASMAX_CK    = 14000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic act_i,
   input  logic wr_i,
   input  logic rda_i,
   input  logic wra_i,
   input  logic pre_i,
   output logic open_o,
   output logic ras_busy_o,
   output logic rc_busy_o,
   output logic rp_busy_o,
   output logic rcd_busy_o,
   output logic rap_busy_o,
   output logic wr_busy_o,
   output logic dal_busy_o,
   output logic overdue_o
);

   logic open_q;
   logic close_w;

   assign close_w = pre_i | rda_i | wra_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      open_q <= 1'b0;
      else if (act_i)   open_q <= 1'b1;
      else if (close_w) open_q <= 1'b0;
   end

   assign open_o = open_q;

   ddr_tchk_dcnt #(.CW(CW)) u_ras (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i),
      .val_i(CW'(ldval(RAS_CK))), .busy_o(ras_busy_o));
   ddr_tchk_dcnt #(.CW(CW)) u_rc  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i),
      .val_i(CW'(ldval(RC_CK))), .busy_o(rc_busy_o));
   ddr_tchk_dcnt #(.CW(CW)) u_rcd (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i),
      .val_i(CW'(ldval(RCD_CK))), .busy_o(rcd_busy_o));
   ddr_tchk_dcnt #(.CW(CW)) u_rap (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i),
      .val_i(CW'(ldval(RAP_CK))), .busy_o(rap_busy_o));
   ddr_tchk_dcnt #(.CW(CW)) u_rp  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(pre_i | rda_i),
      .val_i(CW'(ldval(RP_CK))), .busy_o(rp_busy_o));
   ddr_tchk_dcnt #(.CW(CW)) u_wr  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_i),
      .val_i(CW'(ldval(WREC_CK))), .busy_o(wr_busy_o));
   ddr_tchk_dcnt #(.CW(CW)) u_dal (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(wra_i),
      .val_i(CW'(ldval(DAL_CK))), .busy_o(dal_busy_o));

   generate
      if (ROW_LIMIT_EN) begin : g_age
         logic [AGE_W-1:0] age_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                                       age_q <= '0;
            else if (act_i || close_w)                         age_q <= '0;
            else if (open_q && (age_q < AGE_W'(RASMAX_CK)))    age_q <= age_q + 1'b1;
         end
         assign overdue_o = open_q && (age_q >= AGE_W'(RASMAX_CK));
      end else begin : g_noage
         assign overdue_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ddr_tchk.sv
module ddr_tchk
   import ddr_tchk_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned TCK_PS       = 5000,
   parameter int unsigned T_RAS_PS     = 40000,
   parameter int unsigned T_RASMAX_PS  = 70000000,
   parameter int unsigned T_RC_PS      = 55000,
   parameter int unsigned T_RP_PS      = 15000,
   parameter int unsigned T_RCD_PS     = 15000,
   parameter int unsigned T_RRD_PS     = 10000,
   parameter int unsigned T_WR_PS      = 15000,
   parameter int unsigned T_RFC_PS     = 70000,
   parameter int unsigned T_REFI_PS    = 7800000,
   parameter int unsigned T_XSNR_PS    = 75000,
   parameter int unsigned T_WTR_CK     = 2,
   parameter int unsigned T_CCD_CK     = 1,
   parameter int unsigned T_MRD_CK     = 2,
   parameter int unsigned T_XSRD_CK    = 200,
   parameter int unsigned WDATA_CK     = 3,
   parameter bit          ROW_LIMIT_EN = 1'b1,
   localparam int         BA_W         = $clog2(NUM_BANKS)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            cmd_vld_i,
   input  logic [3:0]      cmd_i,
   input  logic [BA_W-1:0] bank_i,
   output logic            viol_o,
   output logic [3:0]      viol_rule_o,
   output logic            refresh_due_o,
   output logic            row_overdue_o
);

   // Limits in cycles
   localparam int unsigned RAS_CK    = ps2ck(T_RAS_PS, TCK_PS);
   localparam int unsigned RASMAX_CK = ps2ck(T_RASMAX_PS, TCK_PS);
   localparam int unsigned RC_CK     = ps2ck(T_RC_PS, TCK_PS);
   localparam int unsigned RP_CK     = ps2ck(T_RP_PS, TCK_PS);
   localparam int unsigned RCD_CK    = ps2ck(T_RCD_PS, TCK_PS);
   localparam int unsigned RRD_CK    = ps2ck(T_RRD_PS, TCK_PS);
   localparam int unsigned WR_CK     = ps2ck(T_WR_PS, TCK_PS);
   localparam int unsigned RFC_CK    = ps2ck(T_RFC_PS, TCK_PS);
   localparam int unsigned REFI_CK   = ps2ck(T_REFI_PS, TCK_PS);
   localparam int unsigned XSNR_CK   = ps2ck(T_XSNR_PS, TCK_PS);
   localparam int unsigned RAP_CK    = maxu(RCD_CK, RAS_CK);
   localparam int unsigned WREC_CK   = WDATA_CK + WR_CK;
   localparam int unsigned DAL_CK    = WDATA_CK + WR_CK + RP_CK;
   localparam int unsigned WTR_LD_CK = WDATA_CK + T_WTR_CK;

   localparam int unsigned MAX_A  = maxu(maxu(RAS_CK, RC_CK), maxu(RP_CK, RCD_CK));
   localparam int unsigned MAX_B  = maxu(maxu(RAP_CK, WREC_CK), maxu(DAL_CK, RRD_CK));
   localparam int unsigned MAX_C  = maxu(maxu(WTR_LD_CK, T_CCD_CK), maxu(T_MRD_CK, T_XSRD_CK));
   localparam int unsigned MAX_D  = maxu(XSNR_CK, RFC_CK);
   localparam int unsigned MAX_CK = maxu(maxu(MAX_A, MAX_B), maxu(MAX_C, MAX_D));
   localparam int          CW     = $clog2(MAX_CK + 1);
   localparam int          AGE_W  = $clog2(RASMAX_CK + 1);
   localparam int          REFI_W = $clog2(REFI_CK + 1);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (TCK_PS == 0) begin : g_bad_tck
         $error("TCK_PS must be nonzero");
      end
      if (REFI_CK < 2) begin : g_bad_refi
         $error("refresh interval must span at least two cycles");
      end
   endgenerate

   // Command decode
   cmd_e cmd;
   logic live, is_act, is_rd, is_wr, is_rda, is_wra, is_pre, is_ref, is_mrs, is_srx;
   logic is_col, is_read;

   assign cmd     = cmd_e'(cmd_i);
   assign live    = cmd_vld_i && (cmd != CMD_NOP);
   assign is_act  = live && (cmd == CMD_ACT);
   assign is_rd   = live && (cmd == CMD_RD);
   assign is_wr   = live && (cmd == CMD_WR);
   assign is_rda  = live && (cmd == CMD_RDA);
   assign is_wra  = live && (cmd == CMD_WRA);
   assign is_pre  = live && (cmd == CMD_PRE);
   assign is_ref  = live && (cmd == CMD_REF);
   assign is_mrs  = live && (cmd == CMD_MRS);
   assign is_srx  = live && (cmd == CMD_SRX);
   assign is_col  = is_rd | is_wr | is_rda | is_wra;
   assign is_read = is_rd | is_rda;

   // Per-bank trackers
   logic [NUM_BANKS-1:0] open_v, ras_v, rc_v, rp_v, rcd_v, rap_v, wr_v, dal_v, ovd_v;
   logic [NUM_BANKS-1:0] bank_open;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         assign hit = (bank_i == BA_W'(b));
         ddr_tchk_bank #(
            .CW(CW), .AGE_W(AGE_W), .ROW_LIMIT_EN(ROW_LIMIT_EN),
            .RAS_CK(RAS_CK), .RC_CK(RC_CK), .RP_CK(RP_CK), .RCD_CK(RCD_CK),
            .RAP_CK(RAP_CK), .WREC_CK(WREC_CK), .DAL_CK(DAL_CK), .RASMAX_CK(RASMAX_CK)
         ) u_bank (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .act_i(is_act && hit), .wr_i(is_wr && hit), .rda_i(is_rda && hit),
            .wra_i(is_wra && hit), .pre_i(is_pre && hit),
            .open_o(open_v[b]), .ras_busy_o(ras_v[b]), .rc_busy_o(rc_v[b]),
            .rp_busy_o(rp_v[b]), .rcd_busy_o(rcd_v[b]), .rap_busy_o(rap_v[b]),
            .wr_busy_o(wr_v[b]), .dal_busy_o(dal_v[b]), .overdue_o(ovd_v[b])
         );
      end
   endgenerate

   assign bank_open = open_v;

   // Device-wide counters
   logic rrd_busy, wtr_busy, ccd_busy, mrd_busy, xsrd_busy, xsnr_busy, rfc_busy;

   ddr_tchk_dcnt #(.CW(CW)) u_rrd  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_act),
      .val_i(CW'(ldval(RRD_CK))), .busy_o(rrd_busy));
   ddr_tchk_dcnt #(.CW(CW)) u_wtr  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_wr | is_wra),
      .val_i(CW'(ldval(WTR_LD_CK))), .busy_o(wtr_busy));
   ddr_tchk_dcnt #(.CW(CW)) u_ccd  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_col),
      .val_i(CW'(ldval(T_CCD_CK))), .busy_o(ccd_busy));
   ddr_tchk_dcnt #(.CW(CW)) u_mrd  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_mrs),
      .val_i(CW'(ldval(T_MRD_CK))), .busy_o(mrd_busy));
   ddr_tchk_dcnt #(.CW(CW)) u_xsrd (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_srx),
      .val_i(CW'(ldval(T_XSRD_CK))), .busy_o(xsrd_busy));
   ddr_tchk_dcnt #(.CW(CW)) u_xsnr (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_srx),
      .val_i(CW'(ldval(XSNR_CK))), .busy_o(xsnr_busy));
   ddr_tchk_dcnt #(.CW(CW)) u_rfc  (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_ref),
      .val_i(CW'(ldval(RFC_CK))), .busy_o(rfc_busy));

   logic [BA_W-1:0] last_act_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     last_act_q <= '0;
      else if (is_act) last_act_q <= bank_i;
   end

   // Refresh interval tracking
   logic [REFI_W-1:0] refi_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)                          refi_q <= '0;
      else if (is_ref)                      refi_q <= '0;
      else if (refi_q < REFI_W'(REFI_CK))   refi_q <= refi_q + 1'b1;
   end

   // Rule evaluation
   logic open_sel, ras_sel, rc_sel, rp_sel, rcd_sel, rap_sel, wr_sel, dal_sel;
   assign open_sel = open_v[bank_i];
   assign ras_sel  = ras_v[bank_i];
   assign rc_sel   = rc_v[bank_i];
   assign rp_sel   = rp_v[bank_i];
   assign rcd_sel  = rcd_v[bank_i];
   assign rap_sel  = rap_v[bank_i];
   assign wr_sel   = wr_v[bank_i];
   assign dal_sel  = dal_v[bank_i];

   logic [NRULE:0] fail;
   always_comb begin
      fail             = '0;
      fail[RULE_MRD]   = live && mrd_busy;
      fail[RULE_XSNR]  = live && !is_read && xsnr_busy;
      fail[RULE_XSRD]  = is_read && xsrd_busy;
      fail[RULE_RFC]   = (is_act || is_ref) && rfc_busy;
      fail[RULE_NOROW] = is_col && !open_sel;
      fail[RULE_RCD]   = is_col && open_sel && rcd_sel;
      fail[RULE_RAP]   = is_rda && open_sel && rap_sel;
      fail[RULE_CCD]   = is_col && ccd_busy;
      fail[RULE_WTR]   = is_read && wtr_busy;
      fail[RULE_RAS]   = is_pre && open_sel && ras_sel;
      fail[RULE_WREC]  = is_pre && wr_sel;
      fail[RULE_RC]    = (is_act && rc_sel) || (is_ref && (|rc_v));
      fail[RULE_RP]    = is_act && rp_sel;
      fail[RULE_DAL]   = is_act && dal_sel;
      fail[RULE_RRD]   = is_act && rrd_busy && (last_act_q != bank_i);
   end

   rule_e pick;
   always_comb begin
      pick = RULE_NONE;
      for (int r = NRULE; r >= 1; r--) begin
         if (fail[r]) pick = rule_e'(4'(r));
      end
   end

   logic       viol_q;
   logic [3:0] rule_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         viol_q <= 1'b0;
         rule_q <= '0;
      end else begin
         viol_q <= (pick != RULE_NONE);
         rule_q <= pick;
      end
   end

   assign viol_o        = viol_q;
   assign viol_rule_o   = rule_q;
   assign refresh_due_o = (refi_q >= REFI_W'(REFI_CK));
   assign row_overdue_o = |ovd_v;

endmodule

// File: rtl/ddr_tchk_chk.sv
module ddr_tchk_chk #(
   parameter int unsigned NB     = 4,
   parameter int unsigned MRD_CK = 2,
   localparam int         BW     = $clog2(NB)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          cmd_vld_i,
   input logic [3:0]    cmd_i,
   input logic [BW-1:0] bank_i,
   input logic          viol_o,
   input logic [3:0]    viol_rule_o,
   input logic          refresh_due_o,
   input logic          row_overdue_o,
   input logic [NB-1:0] bank_open
);

   logic col_cmd;
   assign col_cmd = cmd_vld_i && (cmd_i >= 4'd2) && (cmd_i <= 4'd5);

   // R2
   code_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |-> (viol_rule_o != 4'd0));

   // R2
   code_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !viol_o |-> (viol_rule_o == 4'd0));

   // R2
   cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |-> $past(cmd_vld_i && (cmd_i != 4'd0)));

   // R3
   mrd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (MRD_CK >= 2 && $past(rst_ni) && $past(cmd_vld_i && cmd_i == 4'd8)
       && cmd_vld_i && cmd_i != 4'd0) |=> (viol_o && viol_rule_o == 4'd1));

   // R6
   closed_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_cmd && !bank_open[bank_i]) |=> (viol_o && viol_rule_o <= 4'd5));

   // R13
   refresh_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_vld_i && cmd_i == 4'd7) |=> !refresh_due_o);

   // R14
   overdue_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_overdue_o |-> (|bank_open));

endmodule

bind ddr_tchk ddr_tchk_chk #(.NB(NUM_BANKS), .MRD_CK(T_MRD_CK)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i),
   .bank_i(bank_i), .viol_o(viol_o), .viol_rule_o(viol_rule_o),
   .refresh_due_o(refresh_due_o), .row_overdue_o(row_overdue_o),
   .bank_open(bank_open)
);

// File: tb/ddr_tchk_test.sv
module ddr_tchk_test;

   localparam int CLK_PERIOD = 10;
   localparam int unsigned TCK_PS      = 5000;
   localparam int unsigned REFI_PS     = 7800000;
   localparam int unsigned RASMAX_PS   = 70000000;
   localparam int unsigned REFI_CYC    = (REFI_PS + TCK_PS - 1) / TCK_PS;
   localparam int unsigned RASMAX_CYC  = (RASMAX_PS + TCK_PS - 1) / TCK_PS;
   localparam int NVEC = 21;

   // {cmd[3:0], bank[1:0], idle[7:0], expected code[3:0], requirement[3:0]}
   localparam logic [21:0] VEC [NVEC] = '{
      {4'd1, 2'd0, 8'd0,  4'd0,  4'd1 },  // R1  ACT b0 right after reset
      {4'd2, 2'd0, 8'd0,  4'd6,  4'd7 },  // R7  READ one cycle after ACT
      {4'd2, 2'd0, 8'd1,  4'd0,  4'd7 },  // R7  READ exactly at tRCD
      {4'd1, 2'd1, 8'd0,  4'd0,  4'd12},  // R12 ACT b1, spacing fine
      {4'd1, 2'd2, 8'd0,  4'd15, 4'd12},  // R12 ACT b2 one cycle after b1
      {4'd6, 2'd0, 8'd0,  4'd10, 4'd9 },  // R9  PRE b0 before tRAS
      {4'd1, 2'd0, 8'd0,  4'd12, 4'd2 },  // R2  RC and RP both fail, RC wins
      {4'd4, 2'd0, 8'd2,  4'd7,  4'd7 },  // R7  READ+AP before tRAS
      {4'd3, 2'd0, 8'd0,  4'd5,  4'd6 },  // R6  WRITE to closed bank
      {4'd3, 2'd1, 8'd0,  4'd0,  4'd6 },  // R6  WRITE to open bank
      {4'd2, 2'd1, 8'd0,  4'd9,  4'd8 },  // R8  READ right after WRITE
      {4'd6, 2'd1, 8'd1,  4'd11, 4'd9 },  // R9  PRE inside write recovery
      {4'd8, 2'd0, 8'd0,  4'd0,  4'd3 },  // R3  MODE SET
      {4'd1, 2'd3, 8'd0,  4'd1,  4'd3 },  // R3  ACT one cycle after MODE SET
      {4'd7, 2'd0, 8'd0,  4'd12, 4'd10},  // R10 REFRESH while bank3 in tRC
      {4'd1, 2'd1, 8'd2,  4'd4,  4'd5 },  // R5  ACT inside tRFC
      {4'd9, 2'd0, 8'd20, 4'd0,  4'd4 },  // R4  SELF-REFRESH EXIT
      {4'd2, 2'd3, 8'd0,  4'd3,  4'd4 },  // R4  READ inside tXSRD
      {4'd6, 2'd3, 8'd0,  4'd2,  4'd4 },  // R4  PRE inside tXSNR
      {4'd5, 2'd2, 8'd20, 4'd0,  4'd11},  // R11 WRITE+AP to open bank2
      {4'd1, 2'd2, 8'd3,  4'd14, 4'd11}   // R11 ACT inside tDAL
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld = 1'b0;
   logic [3:0] cmd = 4'd0;
   logic [1:0] bank = 2'd0;
   logic       viol;
   logic [3:0] rule;
   logic       rdue;
   logic       ovd;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ddr_tchk uut (
      .clk_i(clk), .rst_ni(rst_n), .cmd_vld_i(vld), .cmd_i(cmd), .bank_i(bank),
      .viol_o(viol), .viol_rule_o(rule), .refresh_due_o(rdue), .row_overdue_o(ovd)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; vld = 1'b0; cmd = 4'd0; bank = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive at a negedge, sample the registered result at the next negedge.
   task automatic issue(input logic [3:0] c, input logic [1:0] b, input int idle,
                        input string req, input int exp);
      repeat (idle) @(negedge clk);
      vld = 1'b1; cmd = c; bank = b;
      @(negedge clk);
      vld = 1'b0; cmd = 4'd0;
      chk(req, "pulse", int'(viol), (exp != 0) ? 1 : 0);
      chk(req, "rule code", int'(rule), exp);
   endtask

   initial begin
      // R1: outputs low under reset
      repeat (2) @(negedge clk);
      chk("R1", "viol in reset", int'(viol), 0);
      chk("R1", "rule in reset", int'(rule), 0);
      chk("R1", "refresh_due in reset", int'(rdue), 0);
      chk("R1", "overdue in reset", int'(ovd), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         issue(VEC[i][21:18], VEC[i][17:16], int'(VEC[i][15:8]),
               $sformatf("R%0d", VEC[i][3:0]), int'(VEC[i][7:4]));
      end

      // R10: ACT soon after PRE reports tRP; R2: pulse lasts one cycle
      do_reset();
      issue(4'd1, 2'd0, 0, "R1", 0);
      issue(4'd6, 2'd0, 10, "R9", 0);
      issue(4'd1, 2'd0, 0, "R10", 13);
      @(negedge clk);
      chk("R2", "pulse cleared next cycle", int'(viol), 0);

      // R13: refresh interval threshold
      do_reset();
      issue(4'd7, 2'd0, 0, "R13", 0);
      repeat (REFI_CYC - 1) @(negedge clk);
      chk("R13", "due one cycle early", int'(rdue), 0);
      @(negedge clk);
      chk("R13", "due at interval", int'(rdue), 1);
      issue(4'd7, 2'd0, 0, "R13", 0);
      chk("R13", "due cleared by refresh", int'(rdue), 0);

      // R14: row open-time limit
      do_reset();
      issue(4'd1, 2'd1, 0, "R14", 0);
      repeat (RASMAX_CYC - 1) @(negedge clk);
      chk("R14", "overdue one cycle early", int'(ovd), 0);
      @(negedge clk);
      chk("R14", "overdue at limit", int'(ovd), 1);
      issue(4'd6, 2'd1, 0, "R14", 0);
      chk("R14", "overdue cleared by precharge", int'(ovd), 0);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule